// File: doc/BRIEF.md
# Voltage Regulator Startup Sequencer

This block is the digital heart of a multiphase regulator's power-up. It waits for three qualifying conditions: a good bias supply, the power-enable input and the termination-rail enable. It then walks the reference code for the regulator's DAC through a fixed soft-start profile. The profile has four parts. First comes a quiet delay. A first ramp then carries the reference from zero to a fixed boot code. The reference holds at that boot code for a second fixed interval. A second ramp finally carries it to the processor-requested code less a programmable offset. The requested code is sampled exactly once, on the last cycle of the boot hold.

A requested code outside the accepted range, or equal to the off code, shuts the block down. It stays shut down until one of the three conditions drops and returns. Losing any condition at any moment aborts the sequence. Two outputs are held low throughout shutdown, the startup delay and the latched-off state: the PWM drive enable (low means the phase outputs stay high-impedance) and the reference code. The ready flag follows the registered regulation-window comparator, but only once the reference has settled on its final code.

The interface carries no data stream. Every pin is a plain level-sensitive control or status signal, so no valid/ready handshake or back-pressure applies. The comparators, the DAC and the modulator sit outside the block.

Top module: `vr_startup_seq`

## Requirements
- R1: The sequence leaves shutdown only while `bias_ok`, `pwr_en` and `vtt_en` are all high at once. With any of them low, `pwm_drive_en` and `ref_code` stay 0.
- R2: In shutdown, during the startup delay and while latched off, `pwm_drive_en` is 0 (phase outputs high-impedance) and `ref_code` is 0.
- R3: The first clock edge with all three conditions high enters the delay. The delay lasts D1_CYC cycles. On the next edge `pwm_drive_en` rises and the first ramp starts from 0 toward BOOT_CODE (110 by default, the 1.1 V code).
- R4: While ramping, `ref_code` moves by exactly one LSB every STEP_CYC cycles. The first step comes STEP_CYC edges after the ramp starts.
- R5: Once `ref_code` reaches BOOT_CODE, it holds there. One edge later the boot hold begins, lasting D3_CYC cycles. `vid_code` is sampled only on the final edge of the hold. Values before or after that edge have no effect.
- R6: A code is valid when it lies in VID_MIN..VID_MAX (20..200 by default) and differs from OFF_CODE (0). A valid sampled code makes `ref_code` ramp, up or down, to `vid_code - ofs_code`. If `ofs_code` exceeds the code, the target saturates at 0.
- R7: An invalid code, including OFF_CODE, latches the block off with `ref_code` = 0 and `pwm_drive_en` = 0. Later changes to `vid_code` have no effect. Only a drop and return of `bias_ok`, `pwr_en` or `vtt_en` restarts the sequence.
- R8: `vr_ready` is 1 only once the final target has been reached. It is the value of `in_window` registered one cycle earlier, and it stays 0 throughout every ramp and hold.
- R9: If any of the three conditions falls, the next clock edge forces `vr_ready`, `pwm_drive_en` and `ref_code` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Bias supply above its power-on-reset threshold |
| pwr_en | input | 1 | Power-enable comparator result |
| vtt_en | input | 1 | Termination-rail enable comparator result |
| vid_code | input | CODE_W | Requested output code from the processor |
| ofs_code | input | CODE_W | Offset subtracted from the requested code |
| in_window | input | 1 | Output voltage within the regulation window |
| ref_code | output | CODE_W | Reference code driven to the DAC |
| pwm_drive_en | output | 1 | 1 drives the phases, 0 holds them high-impedance |
| vr_ready | output | 1 | Regulator ready flag |

## Verification
The embedded properties assume the three qualifying inputs and `vid_code` are synchronous to `clk`. They also assume `ofs_code` stays steady around the end of the boot hold. The stimulus changes inputs only one time unit after a rising edge, so every level is stable for a whole cycle before it is used. The vector loop holds each requested code and offset constant for the whole run, and `in_window` stays high except where the ready tests drive it on purpose. Where a test changes `vid_code` during the hold, the change lands on a cycle boundary counted from the edge that enabled the block.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  typedef enum logic [2:0] {
    ST_SHUT  = 3'd0,
    ST_DLY1  = 3'd1,
    ST_RAMP1 = 3'd2,
    ST_HOLD  = 3'd3,
    ST_RAMP2 = 3'd4,
    ST_REG   = 3'd5,
    ST_OFF   = 3'd6
  } vrs_state_e;
endpackage

// File: rtl/vrs_vid_check.sv
module vrs_vid_check #(
  parameter int CODE_W   = 8,
  parameter int VID_MIN  = 20,
  parameter int VID_MAX  = 200,
  parameter int OFF_CODE = 0
) (
  input  logic [CODE_W-1:0] vid,
  input  logic [CODE_W-1:0] ofs,
  output logic              code_ok,
  output logic [CODE_W-1:0] goal
);
  localparam logic [CODE_W-1:0] MIN_C = CODE_W'(VID_MIN);
  localparam logic [CODE_W-1:0] MAX_C = CODE_W'(VID_MAX);
  localparam logic [CODE_W-1:0] OFF_C = CODE_W'(OFF_CODE);

  // range test and off-code test are independent; either failing rejects the code
  always_comb begin
    code_ok = (vid >= MIN_C) && (vid <= MAX_C) && (vid != OFF_C);
    goal    = (vid > ofs) ? (vid - ofs) : '0;
  end

  // R6
  always_comb begin
    target_le_vid_chk: assert (goal <= vid);
  end
endmodule

// File: rtl/vrs_dwell.sv
module vrs_dwell #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;

  assign hit = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!hit)    cnt_q <= cnt_q + 1'b1;
  end

  // R5
  dwell_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && hit) |=> (cnt_q == $past(cnt_q)) || (limit != $past(limit)));
endmodule

// File: rtl/vrs_ramp.sv
module vrs_ramp #(
  parameter int CODE_W   = 8,
  parameter int STEP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [CODE_W-1:0] goal,
  output logic [CODE_W-1:0] code,
  output logic              at_goal
);
  logic [CODE_W-1:0] code_q;
  logic              tick;
  logic              moving;

  assign moving  = run && (code_q != goal);
  assign code    = code_q;
  assign at_goal = (code_q == goal);

  generate
    if (STEP_CYC <= 1) begin : g_every
      assign tick = moving;
    end else begin : g_div
      localparam int SW = $clog2(STEP_CYC);
      localparam logic [SW-1:0] LAST = SW'(STEP_CYC - 1);
      logic [SW-1:0] sc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 sc_q <= '0;
        else if (clear || !moving)  sc_q <= '0;
        else if (sc_q == LAST)      sc_q <= '0;
        else                        sc_q <= sc_q + 1'b1;
      end
      assign tick = moving && (sc_q == LAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          code_q <= '0;
    else if (clear)      code_q <= '0;
    else if (tick) begin
      if (code_q < goal) code_q <= code_q + 1'b1;
      else               code_q <= code_q - 1'b1;
    end
  end

  // R4
  one_lsb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (code_q == $past(code_q)) ||
               (code_q == CODE_W'($past(code_q) + 1'b1)) ||
               (code_q == CODE_W'($past(code_q) - 1'b1)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !run) |=> $stable(code_q));
endmodule

// File: rtl/vr_startup_seq.sv
module vr_startup_seq
  import vrs_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int BOOT_CODE = 110,
  parameter int D1_CYC    = 20,
  parameter int D3_CYC    = 30,
  parameter int STEP_CYC  = 2,
  parameter int VID_MIN   = 20,
  parameter int VID_MAX   = 200,
  parameter int OFF_CODE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bias_ok,
  input  logic              pwr_en,
  input  logic              vtt_en,
  input  logic [CODE_W-1:0] vid_code,
  input  logic [CODE_W-1:0] ofs_code,
  input  logic              in_window,
  output logic [CODE_W-1:0] ref_code,
  output logic              pwm_drive_en,
  output logic              vr_ready
);
  localparam int DW_MAX = (D1_CYC > D3_CYC) ? D1_CYC : D3_CYC;
  localparam int CNT_W  = $clog2(DW_MAX + 1);
  localparam logic [CODE_W-1:0] BOOT_C = CODE_W'(BOOT_CODE);
  localparam logic [CNT_W-1:0]  LIM_D1 = CNT_W'(D1_CYC - 1);
  localparam logic [CNT_W-1:0]  LIM_D3 = CNT_W'(D3_CYC - 1);

  vrs_state_e        state_q, state_d;
  logic              all_ok;
  logic              dwell_hit, dwell_restart;
  logic [CNT_W-1:0]  dwell_lim;
  logic              code_ok;
  logic [CODE_W-1:0] vid_goal, target_q, ramp_goal;
  logic              ramp_clear, ramp_run, ramp_done;
  logic              ready_q;

  assign all_ok = bias_ok & pwr_en & vtt_en;

  vrs_vid_check #(
    .CODE_W(CODE_W), .VID_MIN(VID_MIN), .VID_MAX(VID_MAX), .OFF_CODE(OFF_CODE)
  ) u_vid (
    .vid(vid_code), .ofs(ofs_code), .code_ok(code_ok), .goal(vid_goal)
  );

  // sequencing
  always_comb begin
    state_d = state_q;
    if (!all_ok) begin
      state_d = ST_SHUT;
    end else begin
      unique case (state_q)
        ST_SHUT:  state_d = ST_DLY1;
        ST_DLY1:  if (dwell_hit) state_d = ST_RAMP1;
        ST_RAMP1: if (ramp_done) state_d = ST_HOLD;
        ST_HOLD:  if (dwell_hit) state_d = code_ok ? ST_RAMP2 : ST_OFF;
        ST_RAMP2: if (ramp_done) state_d = ST_REG;
        ST_REG:   state_d = ST_REG;
        ST_OFF:   state_d = ST_OFF;
        default:  state_d = ST_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SHUT;
    else        state_q <= state_d;
  end

  assign dwell_restart = (state_d != state_q);
  assign dwell_lim     = (state_q == ST_DLY1) ? LIM_D1 : LIM_D3;

  vrs_dwell #(.CNT_W(CNT_W)) u_dwell (
    .clk(clk), .rst_n(rst_n), .restart(dwell_restart),
    .limit(dwell_lim), .hit(dwell_hit)
  );

  // requested code captured once, on the last hold cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      target_q <= '0;
    else if (state_q == ST_HOLD && dwell_hit && code_ok && all_ok)
      target_q <= vid_goal;
  end

  assign ramp_clear = (state_d == ST_SHUT) || (state_d == ST_DLY1) ||
                      (state_d == ST_OFF);
  assign ramp_run   = (state_q == ST_RAMP1) || (state_q == ST_RAMP2);
  assign ramp_goal  = (state_q == ST_RAMP1) ? BOOT_C : target_q;

  vrs_ramp #(.CODE_W(CODE_W), .STEP_CYC(STEP_CYC)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clear(ramp_clear), .run(ramp_run),
    .goal(ramp_goal), .code(ref_code), .at_goal(ramp_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= all_ok && (state_q == ST_REG) && in_window;
  end

  assign vr_ready     = ready_q;
  assign pwm_drive_en = (state_q == ST_RAMP1) || (state_q == ST_HOLD) ||
                        (state_q == ST_RAMP2) || (state_q == ST_REG);

  // R9
  drop_shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_ok |=> (!pwm_drive_en && !vr_ready && ref_code == '0));
  // R2
  quiet_states_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHUT || state_q == ST_DLY1 || state_q == ST_OFF)
      |-> (!pwm_drive_en && ref_code == '0));
  // R8
  ready_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vr_ready |-> (state_q == ST_REG && ref_code == target_q));
  // R7
  off_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && all_ok) |=> state_q == ST_OFF);
  // R5
  vid_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_HOLD) |=> $stable(target_q));
  // R3
  ramp1_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_DLY1 && state_q != ST_RAMP1) |=> state_q != ST_RAMP1);
  // R3
  ramp2_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_HOLD && state_q != ST_RAMP2) |=> state_q != ST_RAMP2);
  // R5
  hold_at_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> ref_code == BOOT_C);
endmodule

// File: tb/vr_startup_seq_tb.sv
`timescale 1ns/1ps
module vr_startup_seq_tb_top;
  localparam int CODE_W = 8;
  localparam int BOOT   = 110;
  localparam int D1     = 20;
  localparam int D3     = 30;
  localparam int STEP   = 2;
  localparam int SAMPLE_EDGE = D1 + 1 + BOOT * STEP + D3 + 1;
  localparam int SETTLE = SAMPLE_EDGE + 256 * STEP + 10;

  // {vid, ofs, expected ref_code, expected on}
  localparam int NV = 8;
  localparam logic [24:0] VEC [NV] = '{
    {8'd150, 8'd10, 8'd140, 1'b1},
    {8'd110, 8'd0,  8'd110, 1'b1},
    {8'd60,  8'd5,  8'd55,  1'b1},
    {8'd20,  8'd30, 8'd0,   1'b1},
    {8'd200, 8'd0,  8'd200, 1'b1},
    {8'd0,   8'd0,  8'd0,   1'b0},
    {8'd201, 8'd0,  8'd0,   1'b0},
    {8'd19,  8'd0,  8'd0,   1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bias_ok = 1'b0, pwr_en = 1'b0, vtt_en = 1'b0, in_window = 1'b1;
  logic [CODE_W-1:0] vid_code = '0, ofs_code = '0;
  logic [CODE_W-1:0] ref_code;
  logic pwm_drive_en, vr_ready;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vr_startup_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .pwr_en(pwr_en),
    .vtt_en(vtt_en), .vid_code(vid_code), .ofs_code(ofs_code),
    .in_window(in_window), .ref_code(ref_code),
    .pwm_drive_en(pwm_drive_en), .vr_ready(vr_ready)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic power_up(input int vid, input int ofs);
    {bias_ok, pwr_en, vtt_en} = 3'b000;
    tick(2);
    vid_code = CODE_W'(vid);
    ofs_code = CODE_W'(ofs);
    {bias_ok, pwr_en, vtt_en} = 3'b111;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // reset state (R2)
    check("R2 reset ref_code", ref_code, 0);
    check("R2 reset pwm", pwm_drive_en, 0);
    check("R8 reset ready", vr_ready, 0);

    // R1: only two of three conditions
    vid_code = 8'd150;
    {bias_ok, pwr_en, vtt_en} = 3'b110;
    tick(D1 + 40);
    check("R1 vtt low pwm", pwm_drive_en, 0);
    check("R1 vtt low ref", ref_code, 0);
    {bias_ok, pwr_en, vtt_en} = 3'b011;
    tick(D1 + 40);
    check("R1 bias low pwm", pwm_drive_en, 0);

    // R3/R4 timing from the enabling edge
    power_up(150, 10);
    tick(D1);
    check("R3 delay pwm", pwm_drive_en, 0);
    tick(1);
    check("R3 ramp start pwm", pwm_drive_en, 1);
    tick(STEP - 1);
    check("R4 before first step", ref_code, 0);
    tick(1);
    check("R4 first step", ref_code, 1);
    tick(STEP);
    check("R4 second step", ref_code, 2);
    check("R8 ready low while ramping", vr_ready, 0);

    // R5: vid is off-code during hold, valid only on the sampling edge
    power_up(0, 10);
    tick(D1 + 1 + BOOT * STEP);
    check("R3 boot reached", ref_code, BOOT);
    tick(D3);
    check("R5 boot held", ref_code, BOOT);
    check("R5 pwm during hold", pwm_drive_en, 1);
    vid_code = 8'd150;
    tick(1);
    vid_code = 8'd0;
    tick(SETTLE);
    check("R5 sampled on last hold edge", ref_code, 140);
    check("R8 ready at target", vr_ready, 1);

    // R8: ready tracks registered window
    in_window = 1'b0;
    tick(1);
    check("R8 window low", vr_ready, 0);
    in_window = 1'b1;
    tick(1);
    check("R8 window back", vr_ready, 1);

    // R9: loss of one condition
    vtt_en = 1'b0;
    tick(1);
    check("R9 ready drop", vr_ready, 0);
    check("R9 pwm drop", pwm_drive_en, 0);
    check("R9 ref drop", ref_code, 0);

    // R6/R7: vector table
    for (int i = 0; i < NV; i++) begin
      power_up(int'(VEC[i][24:17]), int'(VEC[i][16:9]));
      tick(SETTLE);
      check("R6 final ref_code", ref_code, int'(VEC[i][8:1]));
      check("R7 drive state", pwm_drive_en, int'(VEC[i][0]));
      check("R8 ready state", vr_ready, int'(VEC[i][0]));
    end

    // R7: latched off ignores new vid; enable cycle restarts
    power_up(0, 10);
    tick(SETTLE);
    check("R7 latched off pwm", pwm_drive_en, 0);
    vid_code = 8'd150;
    tick(SETTLE);
    check("R7 still off ref", ref_code, 0);
    check("R7 still off pwm", pwm_drive_en, 0);
    pwr_en = 1'b0;
    tick(2);
    pwr_en = 1'b1;
    tick(SETTLE);
    check("R7 restart after enable cycle", ref_code, 140);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule